// File: doc/BRIEF.md
# Accumulator-Based Digital Frequency Synthesizer

This block derives a lower-rate clock from a fixed 204.8 MHz master clock by phase accumulation. Each master cycle a 32-bit accumulator advances by a programmed step; the top bit of the accumulator is the coarse output clock. On every rising output edge the block also emits a 4-bit code for where that edge ideally lies within the master period. A downstream edge-placement stage uses this code to move the edge to within a fraction of the 4.88 ns master period.

The step is not written directly. A 3-bit rate code and a 3-bit multiplier code select the step from a menu of telecom rates. The menu covers the 1.544 MHz and 2.048 MHz line rates and 19.44 MHz, each multiplied by N = 1..8, plus the fixed rates 6.312 MHz and 10 MHz. A selection faster than half the master clock, or an unused code, is refused and reported. While the block is disabled it stays silent and its phase is cleared.

Top module: `dfs_synth`

## Requirements
- R1: While `rst_n` is sampled low, all of the following are zero at the next edge: `clk_out`, `edge_stb`, `phase_code`, `cfg_err` and the accumulator.
- R2: The step is the nearest integer to f_out·2^32 / 204.8 MHz. The rate codes are: `rate_sel`=0 gives 1.544 MHz·N, 1 gives 2.048 MHz·N and 4 gives 19.44 MHz·N, where N = `mult_code`+1. Over 4096 master cycles, the number of `edge_stb` pulses is within ±1 of f_out·4096/204.8 MHz.
- R3: `clk_out` is the accumulator MSB. `edge_stb` is high in exactly those cycles in which `clk_out` has just gone from 0 to 1.
- R4: In an `edge_stb` cycle, `phase_code` holds bits [30:27] of the accumulator, that is the top four bits below the MSB after the crossing. In all other cycles it is zero.
- R5: A selection above 102.4 MHz is refused, as are `rate_sel` codes 5 to 7. For a refused selection, `cfg_err` is high in the following cycle and the step in use stays the last accepted one. `cfg_err` drops one cycle after a valid selection.
- R6: One cycle after `en` is sampled low, the accumulator is zero, `clk_out` is low and no `edge_stb` occurs until re-enabled.
- R7: A newly selected step is used from the second master edge after it is presented. The accumulator is never cleared by a rate change, so phase carries across the change.
- R8: `rate_sel`=2 (6.312 MHz) and `rate_sel`=3 (10 MHz) ignore `mult_code`.
- R9: Every accepted step is at most 2^31. The highest accepted menu entry is 19.44 MHz·5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 204.8 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low clears phase and silences output |
| rate_sel | input | 3 | Rate menu code |
| mult_code | input | 3 | Multiplier N minus one |
| clk_out | output | 1 | Coarse synthesized clock |
| edge_stb | output | 1 | One-cycle flag on each rising edge of `clk_out` |
| phase_code | output | 4 | Sub-period position of the flagged edge |
| cfg_err | output | 1 | Last presented selection was refused |

## Verification
The properties assume that `en`, `rate_sel` and `mult_code` are synchronous to the master clock. They also assume that these inputs settle before each edge, because the step register and the error flag sample them every cycle. The stimulus changes these inputs only at falling clock edges and holds each selection for thousands of cycles. The one exception is a deliberate mid-run change, which checks phase continuity against an edge-by-edge model of the accumulator. Refused codes are exercised only after an accepted one, so the retained step is a known rate.

// File: rtl/dfs_pkg.sv
// Shared encodings and constants for the accumulator frequency synthesizer.
// Assumes a fixed master clock; rates are expressed in kHz.
package dfs_pkg;
    localparam int MASTER_KHZ = 204800;
    localparam int ACC_W      = 32;
    localparam int PH_W       = 4;
    localparam int SEL_W      = 3;
    localparam int MUL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        RATE_LINE1544  = 3'd0,
        RATE_LINE2048  = 3'd1,
        RATE_FIX6312   = 3'd2,
        RATE_FIX10000  = 3'd3,
        RATE_OPT19440  = 3'd4
    } rate_e;

    localparam int KHZ_LINE1544 = 1544;
    localparam int KHZ_LINE2048 = 2048;
    localparam int KHZ_FIX6312  = 6312;
    localparam int KHZ_FIX10000 = 10000;
    localparam int KHZ_OPT19440 = 19440;
endpackage

// File: rtl/dfs_inc_lut.sv
// Step lookup: maps a rate code and multiplier code to an accumulator step.
// Every table entry is a constant computed at elaboration. There is no
// runtime divider. Entries above half the master rate, and unused codes,
// come out with ok = 0.
module dfs_inc_lut
    import dfs_pkg::*;
#(
    parameter int ACC_W_P  = ACC_W,
    parameter int MASTER_P = MASTER_KHZ
) (
    input  logic [SEL_W-1:0]   rate_sel,
    input  logic [MUL_W-1:0]   mult_code,
    output logic [ACC_W_P-1:0] inc,
    output logic               ok
);
    localparam int SEL_N   = 1 << SEL_W;
    localparam int MUL_N   = 1 << MUL_W;
    localparam int ENTRIES = SEL_N * MUL_N;

    // Output frequency in kHz for one menu position, 0 when unused.
    function automatic longint unsigned rate_khz(int r, int m);
        case (r)
            int'(RATE_LINE1544): return longint'(KHZ_LINE1544) * longint'(m + 1);
            int'(RATE_LINE2048): return longint'(KHZ_LINE2048) * longint'(m + 1);
            int'(RATE_FIX6312):  return longint'(KHZ_FIX6312);
            int'(RATE_FIX10000): return longint'(KHZ_FIX10000);
            int'(RATE_OPT19440): return longint'(KHZ_OPT19440) * longint'(m + 1);
            default:             return 64'd0;
        endcase
    endfunction

    // Rounded step with a valid bit on top.
    function automatic logic [ACC_W_P:0] make_entry(int r, int m);
        longint unsigned k;
        longint unsigned num;
        logic [ACC_W_P-1:0] step;
        k = rate_khz(r, m);
        if (k == 0 || 2 * k > longint'(MASTER_P))
            return '0;
        num  = (k << ACC_W_P) + longint'(MASTER_P / 2);
        step = ACC_W_P'(num / longint'(MASTER_P));
        return {1'b1, step};
    endfunction

    logic [ACC_W_P:0] tab [ENTRIES];

    // One constant per menu position.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign tab[g] = make_entry(g / MUL_N, g % MUL_N);
    end

    // Select the entry addressed by the configuration.
    assign {ok, inc} = tab[{rate_sel, mult_code}];
endmodule

// File: rtl/dfs_accum.sv
// Phase accumulator with edge detection and sub-period phase code.
// Assumes step <= 2^(ACC_W-1), so the MSB cannot skip a crossing.
// The edge flag and phase code are registered together with the accumulator.
module dfs_accum #(
    parameter int ACC_W_P = 32,
    parameter int PH_W_P  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [ACC_W_P-1:0] step,
    output logic               clk_out,
    output logic               edge_stb,
    output logic [PH_W_P-1:0]  phase_code
);
    localparam int MSB = ACC_W_P - 1;

    logic [ACC_W_P-1:0] acc_q;
    logic [ACC_W_P-1:0] acc_nxt;
    logic               rise;
    logic               edge_q;
    logic [PH_W_P-1:0]  ph_q;

    // Next phase and MSB 0->1 detection.
    always_comb begin
        acc_nxt = acc_q + step;
        rise    = !acc_q[MSB] && acc_nxt[MSB];
    end

    // Advance the phase, or clear it on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc_q  <= '0;
            edge_q <= 1'b0;
            ph_q   <= '0;
        end else begin
            acc_q  <= acc_nxt;
            edge_q <= rise;
            ph_q   <= rise ? acc_nxt[MSB-1 -: PH_W_P] : '0;
        end
    end

    assign clk_out    = acc_q[MSB];
    assign edge_stb   = edge_q;
    assign phase_code = ph_q;
endmodule

// File: rtl/dfs_synth.sv
// Top of the synthesizer. Latches the looked-up step every cycle when it is
// valid, keeps the last accepted step and raises cfg_err otherwise.
// Assumes all inputs are synchronous to the master clock.
module dfs_synth
    import dfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [MUL_W-1:0] mult_code,
    output logic             clk_out,
    output logic             edge_stb,
    output logic [PH_W-1:0]  phase_code,
    output logic             cfg_err
);
    logic [ACC_W-1:0] lut_inc;
    logic             lut_ok;
    logic [ACC_W-1:0] inc_q;
    logic             err_q;

    dfs_inc_lut #(.ACC_W_P(ACC_W), .MASTER_P(MASTER_KHZ)) u_lut (
        .rate_sel  (rate_sel),
        .mult_code (mult_code),
        .inc       (lut_inc),
        .ok        (lut_ok)
    );

    // Step register: accept valid selections, hold on refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= !lut_ok;
            if (lut_ok)
                inc_q <= lut_inc;
        end
    end

    dfs_accum #(.ACC_W_P(ACC_W), .PH_W_P(PH_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step       (inc_q),
        .clk_out    (clk_out),
        .edge_stb   (edge_stb),
        .phase_code (phase_code)
    );

    assign cfg_err = err_q;
endmodule

// File: rtl/dfs_synth_chk.sv
// Property checker for dfs_synth, attached by bind.
module dfs_synth_chk #(
    parameter int ACC_W_P = 32,
    parameter int PH_W_P  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               clk_out,
    input logic               edge_stb,
    input logic [PH_W_P-1:0]  phase_code,
    input logic               cfg_err,
    input logic [ACC_W_P-1:0] inc_q
);
    localparam logic [ACC_W_P-1:0] HALF = {1'b1, {(ACC_W_P-1){1'b0}}};

    p_edge_needs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |-> (clk_out && !$past(clk_out)));

    p_rise_is_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out && !$past(clk_out)) |-> edge_stb);

    p_phase_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_stb |-> (phase_code == '0));

    p_step_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (inc_q == $past(inc_q)));

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!clk_out && !edge_stb));

    p_step_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q <= HALF);
endmodule

bind dfs_synth dfs_synth_chk #(.ACC_W_P(32), .PH_W_P(4)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .clk_out    (clk_out),
    .edge_stb   (edge_stb),
    .phase_code (phase_code),
    .cfg_err    (cfg_err),
    .inc_q      (inc_q)
);

// File: tb/sim_dfs_synth.sv
module sim_dfs_synth;
    localparam int CYC = 10;
    localparam int WIN = 4096;
    localparam longint MK = 204800;

    logic clk = 1'b0;
    always #(CYC/2) clk = ~clk;

    logic       rst_n, en;
    logic [2:0] rate_sel, mult_code;
    logic       clk_out, edge_stb, cfg_err;
    logic [3:0] phase_code;

    int n_chk = 0;
    int n_err = 0;

    dfs_synth u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
        .mult_code(mult_code), .clk_out(clk_out), .edge_stb(edge_stb),
        .phase_code(phase_code), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [2:0]  r;
        logic [2:0]  m;
        logic [31:0] khz;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd0, 32'd1544},  '{3'd0, 3'd7, 32'd12352},
        '{3'd1, 3'd0, 32'd2048},  '{3'd1, 3'd3, 32'd8192},
        '{3'd2, 3'd0, 32'd6312},  '{3'd2, 3'd7, 32'd6312},
        '{3'd3, 3'd5, 32'd10000}, '{3'd4, 3'd0, 32'd19440},
        '{3'd4, 3'd4, 32'd97200}
    };

    task automatic check(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] inc_of(input longint khz);
        return 32'(((khz << 32) + MK / 2) / MK);
    endfunction

    task automatic count_edges(input int cycles, output int cnt);
        cnt = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (edge_stb) cnt++;
        end
    endtask

    task automatic rate_check(input string req, input longint khz);
        int c;
        longint diff;
        repeat (8) @(negedge clk);
        count_edges(WIN, c);
        diff = longint'(c) * MK - khz * WIN;
        check(diff <= MK && diff >= -MK, req, c, (khz * WIN) / MK);
    endtask

    initial begin
        int hi;
        int cnt;
        logic [31:0] m_acc, m_inc, nxt;
        logic        m_edge;
        logic [3:0]  m_ph;
        int bad_w, bad_p, edges;
        rst_n = 1'b0; en = 1'b0; rate_sel = 3'd0; mult_code = 3'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({clk_out, edge_stb, cfg_err, phase_code} == 7'd0, "R1 reset",
              {clk_out, edge_stb, cfg_err, phase_code}, 0);
        rst_n = 1'b1;
        en = 1'b1;

        // Table walk: R2 rates, R8 ignored multiplier, R9 top accepted entry
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i == 5 || i == 6) ? "R8" : (i == 8) ? "R9" : "R2";
            rate_sel  = VEC[i].r;
            mult_code = VEC[i].m;
            rate_check(tag, longint'(VEC[i].khz));
            check(cfg_err == 1'b0, {tag, " accepted"}, cfg_err, 0);
        end

        // R5: over-range selection refused, previous rate kept
        rate_sel = 3'd4; mult_code = 3'd5;
        @(negedge clk); @(negedge clk);
        check(cfg_err == 1'b1, "R5 over-range flag", cfg_err, 1);
        rate_check("R5 step kept (over-range)", 97200);
        rate_sel = 3'd6; mult_code = 3'd0;
        @(negedge clk); @(negedge clk);
        check(cfg_err == 1'b1, "R5 unused code flag", cfg_err, 1);
        rate_check("R5 step kept (unused code)", 97200);
        rate_sel = 3'd1;
        @(negedge clk); @(negedge clk);
        check(cfg_err == 1'b0, "R5 flag clears", cfg_err, 0);

        // R6: disable silences the output
        en = 1'b0;
        @(negedge clk);
        check(!clk_out && !edge_stb, "R6 immediate", {clk_out, edge_stb}, 0);
        hi = 0;
        repeat (200) begin
            @(negedge clk);
            if (clk_out || edge_stb) hi++;
        end
        check(hi == 0, "R6 quiet", hi, 0);

        // R3 R4 R7: cycle-exact model from a cleared phase with a rate change mid-run
        rate_sel = 3'd3; mult_code = 3'd0;
        repeat (3) @(negedge clk);
        m_acc = 32'd0; m_inc = inc_of(10000);
        bad_w = 0; bad_p = 0; edges = 0;
        en = 1'b1;
        for (int i = 0; i < 120; i++) begin
            @(posedge clk);
            nxt    = m_acc + m_inc;
            m_edge = !m_acc[31] && nxt[31];
            m_ph   = nxt[30:27];
            m_acc  = nxt;
            m_inc  = (rate_sel == 3'd4) ? inc_of(38880) : inc_of(10000);
            @(negedge clk);
            if (clk_out !== m_acc[31] || edge_stb !== m_edge) bad_w++;
            if (m_edge) begin
                edges++;
                if (phase_code !== m_ph) bad_p++;
            end else if (phase_code !== 4'd0) begin
                bad_p++;
            end
            if (i == 59) begin
                rate_sel = 3'd4; mult_code = 3'd1;
            end
        end
        check(bad_w == 0, "R3 R7 clock/edge vs model", bad_w, 0);
        check(bad_p == 0, "R4 phase code vs model", bad_p, 0);
        check(edges >= 10, "R4 edges seen", edges, 10);

        // R1: reset in the middle of a run
        count_edges(5, cnt);
        rst_n = 1'b0;
        @(negedge clk);
        check({clk_out, edge_stb, cfg_err, phase_code} == 7'd0, "R1 mid-run reset",
              {clk_out, edge_stb, cfg_err, phase_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule